// File: doc/BRIEF.md
# Power-Management Event Collector with SCI Gating

This block collects wake and power-management events and decides when the host should see a System Control Interrupt (SCI). It takes eight event sources:

- three asynchronous wake pins;
- a thermal alarm;
- a USB event;
- an SMI event;
- a PME raised by GPIO activity;
- a power-up request.

Each source latches a sticky status bit. Software clears a status bit by writing 1 to it.

An SCI reaches the host only when three conditions hold together: the status bit is set, the matching enable bit is set, and the global SCI enable is set. The SCI output is a level. It stays high until every enabled status bit has been cleared or disabled, or until the global enable is dropped.

Each wake pin passes through a two-flop synchronizer and a debounce filter. The debounce time is a cycle count computed from the clock frequency and a time in nanoseconds. By default this is about 31 µs. A debounced wake event can be routed to the SMI output instead of the status logic, one override bit per pin. Software reaches the block through a small word-wide register port. Reads are combinational and writes are single-cycle.

Top module: `pm_evt_sci`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and control registers read 0, and `sci_o` and `smi_o` are low.
- R2: A source that is high at a clock edge sets its status bit, and the bit stays set. Status bit positions at address 0: bit0 power-up request, bit1 GPIO PME, bit2 SMI event, bit3 thermal alarm, bit4 USB event, bits 5/6/7 wake pins 0/1/2.
- R3: A write to address 0 clears every status bit written as 1. Bits written as 0 keep their value.
- R4: If a source is high in the same cycle that software writes 1 to its status bit, the bit stays set.
- R5: `sci_o` is high exactly when the SCI enable is set and at least one status bit has its matching enable bit set.
- R6: The enable register at address 1 holds bits 7:0, using the same positions as the status register. Bits 15:8 ignore writes and read 0.
- R7: The control register at address 2 has SCI enable at bit 0 and wake-pin overrides at bits 1/2/3 for pins 0/1/2. Its other bits read 0. Status bits 15:8 read 0, and address 3 reads 0.
- R8: A wake pin's new level is recognised only after the synchronized input has differed from the accepted level for DEB_CYCLES consecutive clocks. Both a rising and a falling accepted change produce one event. A shorter excursion produces none.
- R9: While a pin's override bit is set, that pin's event pulses `smi_o` high for one clock and does not set its status bit. This holds whatever the enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_pin_i | input | 3 | Asynchronous wake pins |
| thermal_i | input | 1 | Thermal alarm event, synchronous, active high |
| usb_evt_i | input | 1 | USB event, synchronous |
| smi_evt_i | input | 1 | SMI event, synchronous |
| gpio_pme_i | input | 1 | GPIO-caused PME, synchronous |
| pwrup_req_i | input | 1 | Power-up request, synchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| sci_o | output | 1 | Level SCI request |
| smi_o | output | 1 | One-clock SMI request from overridden wake pins |

## Verification
The assertions assume the following about the inputs:

- The five non-pin event inputs are already synchronous to `clk`.
- The wake pins may change at any time.
- The register port presents one write per cycle at a stable address.

The bench drives every input at the falling edge, so all inputs are settled at the rising edge. It only moves the wake pins for whole clock periods.

The glitch test holds a pin for fewer clocks than the debounce count. The accepted-change tests hold a pin well beyond that count. The bench therefore never depends on sub-cycle synchronizer behaviour, and the event cycle follows directly from the register count along the path.

// File: rtl/pm_evt_pkg.sv
// Shared constants and types for the power-management event collector.
// Assumes an eight-source status layout and a two-bit register address space.
package pm_evt_pkg;
    localparam int NUM_WAKE = 3;
    localparam int NUM_SRC  = 8;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 2;

    // Status and enable bit positions (decoded by software)
    localparam int SB_PWRUP = 0;
    localparam int SB_GPIO  = 1;
    localparam int SB_SMI   = 2;
    localparam int SB_THERM = 3;
    localparam int SB_USB   = 4;
    localparam int SB_WAKE0 = 5;

    // Control register layout
    localparam int CB_SCI_EN = 0;
    localparam int CB_OVR0   = 1;

    localparam logic [REG_W-1:0] EN_MASK   = REG_W'((1 << NUM_SRC) - 1);
    localparam logic [REG_W-1:0] CTRL_MASK = REG_W'((1 << (NUM_WAKE + 1)) - 1);

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 2'd0,
        RA_ENABLE = 2'd1,
        RA_CTRL   = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pm_wake_filter.sv
// Synchronizes one asynchronous wake pin and debounces it.
// A change is accepted once the synchronized value has differed from the
// accepted level for DEB_CYCLES consecutive clocks; every accepted change
// (either direction) gives a one-clock event. Assumes DEB_CYCLES >= 1.
module pm_wake_filter #(
    parameter int DEB_CYCLES = 1023
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic evt_o
);
    localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic [1:0]       sync_q;
    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             evt_q;

    // Two-flop synchronizer for the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pin_i};
    end

    // Debounce counter: accept the new level after a full stable window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else if (sync_q[1] != lvl_q) begin
            if (cnt_q == CNT_LAST) begin
                lvl_q <= sync_q[1];
                cnt_q <= '0;
                evt_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                evt_q <= 1'b0;
            end
        end else begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end
    end

    assign evt_o = evt_q;

    AST_EVT_MOVES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> (lvl_q != $past(lvl_q))); // R8
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[1] == lvl_q) |=> $stable(lvl_q)); // R8
endmodule

// File: rtl/pm_evt_status.sv
// Sticky status bits, cleared by write-1. A set request in the same cycle
// as a clear keeps the bit set. Assumes set_i is synchronous to clk.
module pm_evt_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] stat_q;

    // Per-bit sticky latch with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    assign stat_o = stat_q;

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R4
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(clr_i) & $past(stat_q)) == ($past(stat_q) & ~$past(clr_i)))); // R3
endmodule

// File: rtl/pm_evt_regs.sv
// Enable and control registers plus the read multiplexer. Produces the
// write-1 clear vector for the status bits. Assumes one access per cycle.
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [REG_W-1:0]    wdata_i,
    input  logic [NUM_SRC-1:0]  stat_i,
    output logic [NUM_SRC-1:0]  clr_o,
    output logic [NUM_SRC-1:0]  en_o,
    output logic                sci_en_o,
    output logic [NUM_WAKE-1:0] ovr_o,
    output logic [REG_W-1:0]    rdata_o
);
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] ctrl_q;
    reg_addr_e        ra;

    assign ra = reg_addr_e'(addr_i);

    // Writable register storage; reserved bits are masked to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ctrl_q <= '0;
        end else if (wr_i) begin
            if (ra == RA_ENABLE) en_q   <= wdata_i & EN_MASK;
            if (ra == RA_CTRL)   ctrl_q <= wdata_i & CTRL_MASK;
        end
    end

    // Write-1 clear vector toward the status bits
    always_comb begin
        clr_o = '0;
        if (wr_i && ra == RA_STATUS) clr_o = wdata_i[NUM_SRC-1:0];
    end

    // Read multiplexer
    always_comb begin
        unique case (ra)
            RA_STATUS: rdata_o = REG_W'(stat_i);
            RA_ENABLE: rdata_o = en_q;
            RA_CTRL:   rdata_o = ctrl_q;
            default:   rdata_o = '0;
        endcase
    end

    assign en_o     = en_q[NUM_SRC-1:0];
    assign sci_en_o = ctrl_q[CB_SCI_EN];
    assign ovr_o    = ctrl_q[CB_OVR0 +: NUM_WAKE];

    AST_EN_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en_q[REG_W-1:NUM_SRC] == '0)); // R6
endmodule

// File: rtl/pm_evt_sci.sv
// Top of the power-management event collector: filters the wake pins,
// latches all events into sticky status, and gates the SCI with per-source
// and global enables. Overridden wake pins drive smi_o instead of status.
// Assumes the non-pin event inputs are synchronous to clk.
module pm_evt_sci
    import pm_evt_pkg::*;
#(
    parameter int CLK_MHZ     = 33,
    parameter int DEBOUNCE_NS = 31000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          wake_pin_i,
    input  logic                thermal_i,
    input  logic                usb_evt_i,
    input  logic                smi_evt_i,
    input  logic                gpio_pme_i,
    input  logic                pwrup_req_i,
    input  logic                reg_wr_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [15:0]         reg_wdata_i,
    output logic [15:0]         reg_rdata_o,
    output logic                sci_o,
    output logic                smi_o
);
    localparam int DEB_RAW    = (CLK_MHZ * DEBOUNCE_NS) / 1000;
    localparam int DEB_CYCLES = (DEB_RAW < 1) ? 1 : DEB_RAW;

    logic [NUM_WAKE-1:0] wake_evt;
    logic [NUM_WAKE-1:0] ovr;
    logic [NUM_SRC-1:0]  set_vec;
    logic [NUM_SRC-1:0]  clr_vec;
    logic [NUM_SRC-1:0]  stat;
    logic [NUM_SRC-1:0]  en;
    logic                sci_en;

    // One synchronizer and debounce filter per wake pin
    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_wake
        pm_wake_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (wake_pin_i[g]),
            .evt_o (wake_evt[g])
        );
    end

    // Route each event to its status bit; overridden wake events are withheld
    always_comb begin
        set_vec           = '0;
        set_vec[SB_PWRUP] = pwrup_req_i;
        set_vec[SB_GPIO]  = gpio_pme_i;
        set_vec[SB_SMI]   = smi_evt_i;
        set_vec[SB_THERM] = thermal_i;
        set_vec[SB_USB]   = usb_evt_i;
        set_vec[SB_WAKE0 +: NUM_WAKE] = wake_evt & ~ovr;
    end

    pm_evt_status #(.N(NUM_SRC)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    pm_evt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .stat_i   (stat),
        .clr_o    (clr_vec),
        .en_o     (en),
        .sci_en_o (sci_en),
        .ovr_o    (ovr),
        .rdata_o  (reg_rdata_o)
    );

    // Three-gate SCI: status, per-source enable, global enable
    assign sci_o = sci_en & (|(stat & en));
    // SMI from any overridden wake pin event
    assign smi_o = |(ovr & wake_evt);

    AST_SCI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sci_o |-> (sci_en && (stat != '0))); // R5
    AST_SMI_NEEDS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> (ovr != '0)); // R9
    AST_OVR_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovr & wake_evt) != '0) |=>
        ((stat[SB_WAKE0 +: NUM_WAKE] & ~$past(stat[SB_WAKE0 +: NUM_WAKE])
          & $past(ovr & wake_evt)) == '0)); // R9
endmodule

// File: tb/sim_pm_evt_sci.sv
// Bench for pm_evt_sci: behavioural reference model compared every clock,
// plus directed register reads.
module sim_pm_evt_sci;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ  = 1;
    localparam int DNS  = 6000;
    localparam int DEB  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  wake_pin = '0;
    logic        thermal = 0, usb = 0, smi_ev = 0, gpio = 0, pwrup = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sci, smi;

    int errors = 0;
    int checks = 0;
    int smi_seen = 0;
    string cur_req = "R1";
    bit model_ok = 0;
    bit done = 0;

    // Model state
    bit        m_s1 [3];
    bit        m_s2 [3];
    bit        m_lvl[3];
    int        m_cnt[3];
    bit        m_evt[3];
    bit [7:0]  m_stat;
    bit [7:0]  m_en;
    bit        m_sci_en;
    bit [2:0]  m_ovr;

    pm_evt_sci #(.CLK_MHZ(MHZ), .DEBOUNCE_NS(DNS)) u0 (
        .clk(clk), .rst_n(rst_n), .wake_pin_i(wake_pin), .thermal_i(thermal),
        .usb_evt_i(usb), .smi_evt_i(smi_ev), .gpio_pme_i(gpio),
        .pwrup_req_i(pwrup), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sci_o(sci), .smi_o(smi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit [15:0] m_read(bit [1:0] a);
        case (a)
            2'd0: return {8'h00, m_stat};
            2'd1: return {8'h00, m_en};
            2'd2: return {12'h000, m_ovr, m_sci_en};
            default: return 16'h0000;
        endcase
    endfunction

    // Reference model, updated at each rising edge from pre-edge values
    always @(posedge clk) begin
        bit [7:0] set_v, clr_v;
        bit [2:0] evt_old;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0; m_cnt[i] = 0; m_evt[i] = 0;
            end
            m_stat = 0; m_en = 0; m_sci_en = 0; m_ovr = 0;
        end else begin
            for (int i = 0; i < 3; i++) evt_old[i] = m_evt[i];
            set_v = {evt_old & ~m_ovr, usb, thermal, smi_ev, gpio, pwrup};
            clr_v = (reg_wr && reg_addr == 2'd0) ? reg_wdata[7:0] : 8'h00;
            m_stat = (m_stat & ~clr_v) | set_v;
            if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata[7:0];
            if (reg_wr && reg_addr == 2'd2) begin
                m_sci_en = reg_wdata[0];
                m_ovr = reg_wdata[3:1];
            end
            for (int i = 0; i < 3; i++) begin
                m_evt[i] = 0;
                if (m_s2[i] != m_lvl[i]) begin
                    if (m_cnt[i] + 1 >= DEB) begin
                        m_lvl[i] = m_s2[i]; m_cnt[i] = 0; m_evt[i] = 1;
                    end else m_cnt[i]++;
                end else m_cnt[i] = 0;
                m_s2[i] = m_s1[i];
                m_s1[i] = wake_pin[i];
            end
        end
        model_ok = 1;
    end

    // Every-clock comparison, a quarter period after the edge
    always @(posedge clk) begin
        bit [2:0] ev;
        #(CLK_PERIOD/4);
        if (model_ok && !done) begin
            for (int i = 0; i < 3; i++) ev[i] = m_evt[i];
            check(cur_req, "sci_o", sci, int'(m_sci_en && ((m_stat & m_en) != 0)));
            check("R9", "smi_o", smi, int'((m_ovr & ev) != 0));
            check(cur_req, "rdata", reg_rdata, m_read(reg_addr));
            if (smi) smi_seen++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit [1:0] a, bit [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(bit [1:0] a, bit [15:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, "read", reg_rdata, exp);
    endtask

    task automatic pulse_src(int which);
        @(negedge clk);
        case (which)
            0: pwrup = 1; 1: gpio = 1; 2: smi_ev = 1; 3: thermal = 1; default: usb = 1;
        endcase
        @(negedge clk);
        pwrup = 0; gpio = 0; smi_ev = 0; thermal = 0; usb = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        cur_req = "R1";
        rd(2'd0, 16'h0000, "R1");
        rd(2'd1, 16'h0000, "R1");
        rd(2'd2, 16'h0000, "R1");
        check("R1", "sci reset", sci, 0);
        check("R1", "smi reset", smi, 0);
        @(negedge clk); rst_n = 1;
        tick(2);

        // R2: each synchronous source sets its own bit and it sticks
        cur_req = "R2";
        for (int s = 0; s < 5; s++) begin
            pulse_src(s);
            tick(2);
            rd(2'd0, 16'((1 << (s + 1)) - 1), "R2");
        end

        // R3: write 0 no effect, write 1 clears chosen bits
        cur_req = "R3";
        wr(2'd0, 16'h0000);
        rd(2'd0, 16'h001F, "R3");
        wr(2'd0, 16'h0005);
        rd(2'd0, 16'h001A, "R3");

        // R6: enable register writable bits and reserved bits
        cur_req = "R6";
        wr(2'd1, 16'hFFFF);
        rd(2'd1, 16'h00FF, "R6");
        check("R5", "sci without global enable", sci, 0);

        // R5: global enable gates SCI
        cur_req = "R5";
        wr(2'd2, 16'h0001);
        tick(1);
        check("R5", "sci all gates set", sci, 1);
        wr(2'd1, 16'h0005);
        tick(1);
        check("R5", "sci enabled bits clear", sci, 0);
        wr(2'd1, 16'h0008);
        tick(1);
        check("R5", "sci thermal enabled", sci, 1);
        wr(2'd2, 16'h0000);
        tick(1);
        check("R5", "sci global off", sci, 0);
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'h00FF);
        tick(1);
        check("R5", "sci after clear", sci, 0);

        // R4: set beats clear in the same cycle
        cur_req = "R4";
        @(negedge clk);
        usb = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h0010;
        @(negedge clk);
        usb = 0; reg_wr = 0; reg_wdata = '0;
        rd(2'd0, 16'h0010, "R4");
        wr(2'd0, 16'h0010);

        // R8: short glitch ignored, long hold accepted both ways
        cur_req = "R8";
        wr(2'd1, 16'h00E0);
        @(negedge clk); wake_pin[0] = 1;
        tick(DEB - 2);
        @(negedge clk); wake_pin[0] = 0;
        tick(DEB + 6);
        rd(2'd0, 16'h0000, "R8");
        @(negedge clk); wake_pin[0] = 1;
        tick(DEB + 6);
        rd(2'd0, 16'h0020, "R8");
        check("R8", "sci from wake0", sci, 1);
        wr(2'd0, 16'h0020);
        @(negedge clk); wake_pin[0] = 0;
        tick(DEB + 6);
        rd(2'd0, 16'h0020, "R8");
        wr(2'd0, 16'h0020);
        @(negedge clk); wake_pin[2] = 1;
        tick(DEB + 6);
        rd(2'd0, 16'h0080, "R8");
        wr(2'd0, 16'h0080);

        // R9: override sends wake1 to SMI, status untouched
        cur_req = "R9";
        smi_seen = 0;
        wr(2'd2, 16'h0005);
        @(negedge clk); wake_pin[1] = 1;
        tick(DEB + 6);
        rd(2'd0, 16'h0000, "R9");
        check("R9", "smi pulses seen", smi_seen, 1);
        check("R9", "no sci", sci, 0);

        // R7: control reserved bits, spare address, status upper bits
        cur_req = "R7";
        wr(2'd2, 16'hFFF0);
        rd(2'd2, 16'h0000, "R7");
        wr(2'd2, 16'h000F);
        rd(2'd2, 16'h000F, "R7");
        wr(2'd3, 16'hFFFF);
        rd(2'd3, 16'h0000, "R7");
        wr(2'd0, 16'hFF00);
        rd(2'd0, 16'h0000, "R7");

        tick(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule